// File: doc/BRIEF.md
# Reset and Boot Mode Sequencer

This block sits between the chip's master reset and the processor core. When reset is released it first counts a fixed power-up hold so the clock generator can settle, sampling three strap pins every cycle of that window. The last sample is frozen and picks one of three start-up strategies. Once no external bus request is pending, the chosen strategy runs, and then the core is released.

In the byte-load strategy the sequencer reads bytes one per cycle from a byte-wide boot memory. It packs each group of three into a 24-bit word, most significant byte first, and writes a fixed number of words (32 by default) into internal program memory from address 0 upward. In the no-load strategy the core is released at once and told to fetch from external address 0. In the host-load strategy the sequencer watches host writes into program memory and releases the core after the first write that hits address 0. In all cases other than no-load, the core starts from internal address 0.

Top module: `boot_seq_ctrl`

## Requirements
- R1: For HOLD_CYCLES clock edges after reset is released, core_run_o, boot_done_o, boot_irq_o, fetch_ext_o, bm_rd_o and pm_we_o all stay low.
- R2: mode_i is sampled on each of those hold edges. The value at the last hold edge decides the strategy, and later changes of mode_i have no effect until the next reset.
- R3: Decoding of mode_i = {c,b,a}: b=1 with c=0 selects no-load; c=1 with a=1 selects host-load; every other value selects byte-load.
- R4: After the hold, no strategy starts while bus_req_i is high. The strategy starts on the first edge at which bus_req_i is sampled low.
- R5: Byte-load issues reads of byte addresses 0 to 3*BOOT_WORDS-1 on consecutive cycles, starting in the first cycle after the start edge, with one read per cycle. Read data is taken from bm_data_i in the cycle after the read.
- R6: Word w equals {byte 3w, byte 3w+1, byte 3w+2}, with the first byte in bits 23:16. It is written to pm_addr_o = w with pm_we_o high in the cycle in which byte 3w+2 returns.
- R7: In byte-load, core_run_o and boot_done_o rise in the cycle after the last word write. In that same cycle boot_irq_o is high for exactly one cycle, and fetch_ext_o stays low.
- R8: In no-load, core_run_o, boot_done_o and fetch_ext_o rise in the cycle after the start edge. No reads, writes or interrupt occur.
- R9: In host-load, core_run_o and boot_done_o rise in the cycle after an edge at which host_we_i is high and host_addr_i is 0. Host writes to other addresses, or made before the wait for the host has begun, are ignored. No interrupt occurs, and fetch_ext_o stays low.
- R10: Once core_run_o is high, it and boot_done_o stay high until the next reset.
- R11: Asserting rst_ni at any time forces all outputs low at once, including in the middle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| mode_i | input | 3 | Strategy strap pins {c,b,a} |
| bus_req_i | input | 1 | External bus request pending; delays the start |
| bm_rd_o | output | 1 | Byte memory read strobe |
| bm_addr_o | output | BM_AW | Byte memory address |
| bm_data_i | input | 8 | Byte memory data, valid the cycle after a read |
| pm_we_o | output | 1 | Program memory write enable |
| pm_addr_o | output | PM_AW | Program memory word address |
| pm_wdata_o | output | 24 | Packed program word |
| host_we_i | input | 1 | Host writes program memory this cycle |
| host_addr_i | input | PM_AW | Program address of the host write |
| core_run_o | output | 1 | Core may fetch (low holds the core) |
| fetch_ext_o | output | 1 | First fetch comes from external address 0 |
| boot_done_o | output | 1 | Boot finished; rises with core_run_o |
| boot_irq_o | output | 1 | One-cycle interrupt request when a byte load finishes |

## Verification
Two events can fall in the same cycle at the start edge: the hold ending and a host write to address 0. The bench drives such a write on exactly the edge that moves the sequencer into its host wait, and expects the core to stay held until a later write to address 0. A second case is the last packed word write together with the release of the core. A reference model steps on every clock and predicts the cycle of the last write, the release, and the single interrupt cycle, so the bench can confirm that the write and the release land in adjacent cycles and never overlap. A host write to address 0 issued in the middle of a byte load checks that the host path stays disarmed during a load.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int BYTE_W = 8;
  localparam int BPW    = 3;
  localparam int WORD_W = BYTE_W * BPW;

  typedef enum logic [1:0] {BOOT_BYTE, BOOT_NONE, BOOT_HOST} boot_mode_e;
  typedef enum logic [1:0] {ST_HOLD, ST_LOAD, ST_HOST, ST_RUN} seq_state_e;

  // pins = {c,b,a}
  function automatic boot_mode_e decode_mode(input logic [2:0] pins);
    if (pins[1] && !pins[2])      return BOOT_NONE;
    else if (pins[2] && pins[0])  return BOOT_HOST;
    else                          return BOOT_BYTE;
  endfunction
endpackage

// File: rtl/por_hold.sv
module por_hold #(
  parameter int HOLD_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q < CNT_W'(HOLD_CYCLES)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CNT_W'(HOLD_CYCLES));
endmodule

// File: rtl/mode_capture.sv
module mode_capture
  import boot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_done_i,
  input  logic [2:0] mode_i,
  output boot_mode_e mode_o
);
  logic [2:0] pins_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pins_q <= '0;
    else if (!hold_done_i) pins_q <= mode_i;
  end

  assign mode_o = decode_mode(pins_q);
endmodule

// File: rtl/host_watch.sv
module host_watch #(
  parameter int PM_AW = 14
) (
  input  logic             arm_i,
  input  logic             host_we_i,
  input  logic [PM_AW-1:0] host_addr_i,
  output logic             hit_o
);
  assign hit_o = arm_i && host_we_i && (host_addr_i == '0);
endmodule

// File: rtl/byte_loader.sv
module byte_loader
  import boot_pkg::*;
#(
  parameter int BOOT_WORDS = 32,
  parameter int BM_AW      = 22,
  parameter int PM_AW      = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic              bm_rd_o,
  output logic [BM_AW-1:0]  bm_addr_o,
  input  logic [BYTE_W-1:0] bm_data_i,
  output logic              pm_we_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [WORD_W-1:0] pm_wdata_o,
  output logic              last_o
);
  localparam int NBYTES = BOOT_WORDS * BPW;
  localparam int RD_CW  = $clog2(NBYTES + 1);
  localparam int WD_CW  = (BOOT_WORDS > 1) ? $clog2(BOOT_WORDS) : 1;
  localparam int SH_W   = WORD_W - BYTE_W;

  logic [RD_CW-1:0] rd_cnt_q;
  logic             ret_v_q;
  logic [1:0]       ph_q;
  logic [WD_CW-1:0] word_q;
  logic [SH_W-1:0]  sh_q;

  assign bm_rd_o   = en_i && (rd_cnt_q < RD_CW'(NBYTES));
  assign bm_addr_o = BM_AW'(rd_cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q <= '0;
      ret_v_q  <= 1'b0;
      ph_q     <= '0;
      word_q   <= '0;
      sh_q     <= '0;
    end else begin
      ret_v_q <= bm_rd_o;
      if (bm_rd_o) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (ret_v_q) begin
        sh_q <= {sh_q[SH_W-BYTE_W-1:0], bm_data_i};
        if (ph_q == 2'(BPW - 1)) begin
          ph_q   <= '0;
          word_q <= word_q + 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  // last byte of a word is written straight from the return bus
  assign pm_we_o    = ret_v_q && (ph_q == 2'(BPW - 1));
  assign pm_addr_o  = PM_AW'(word_q);
  assign pm_wdata_o = {sh_q, bm_data_i};
  assign last_o     = pm_we_o && (word_q == WD_CW'(BOOT_WORDS - 1));
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_pkg::*;
#(
  parameter int HOLD_CYCLES = 2000,
  parameter int BOOT_WORDS  = 32,
  parameter int BM_AW       = 22,
  parameter int PM_AW       = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic              bus_req_i,
  output logic              bm_rd_o,
  output logic [BM_AW-1:0]  bm_addr_o,
  input  logic [7:0]        bm_data_i,
  output logic              pm_we_o,
  output logic [PM_AW-1:0]  pm_addr_o,
  output logic [23:0]       pm_wdata_o,
  input  logic              host_we_i,
  input  logic [PM_AW-1:0]  host_addr_i,
  output logic              core_run_o,
  output logic              fetch_ext_o,
  output logic              boot_done_o,
  output logic              boot_irq_o
);
  seq_state_e state_q, state_d;
  boot_mode_e mode_sel;
  logic       hold_done, load_last, host_hit;
  logic       irq_q, ext_q;

  por_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i, .rst_ni, .done_o(hold_done)
  );

  mode_capture u_mode (
    .clk_i, .rst_ni, .hold_done_i(hold_done), .mode_i, .mode_o(mode_sel)
  );

  byte_loader #(.BOOT_WORDS(BOOT_WORDS), .BM_AW(BM_AW), .PM_AW(PM_AW)) u_load (
    .clk_i, .rst_ni,
    .en_i(state_q == ST_LOAD),
    .bm_rd_o, .bm_addr_o, .bm_data_i,
    .pm_we_o, .pm_addr_o, .pm_wdata_o,
    .last_o(load_last)
  );

  host_watch #(.PM_AW(PM_AW)) u_host (
    .arm_i(state_q == ST_HOST), .host_we_i, .host_addr_i, .hit_o(host_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_HOLD:
        if (hold_done && !bus_req_i) begin
          unique case (mode_sel)
            BOOT_NONE: state_d = ST_RUN;
            BOOT_HOST: state_d = ST_HOST;
            default:   state_d = ST_LOAD;
          endcase
        end
      ST_LOAD: if (load_last) state_d = ST_RUN;
      ST_HOST: if (host_hit)  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      irq_q   <= 1'b0;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= (state_q == ST_LOAD) && load_last;
      if (state_q == ST_HOLD && state_d == ST_RUN) ext_q <= 1'b1;
    end
  end

  assign core_run_o  = (state_q == ST_RUN);
  assign boot_done_o = core_run_o;
  assign boot_irq_o  = irq_q;
  assign fetch_ext_o = ext_q;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
  import boot_pkg::*;
#(
  parameter int BM_AW = 22
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hold_done_i,
  input boot_mode_e       mode_sel_i,
  input logic             host_arm_i,
  input logic             bus_req_i,
  input logic             bm_rd_i,
  input logic [BM_AW-1:0] bm_addr_i,
  input logic             pm_we_i,
  input logic             core_run_i,
  input logic             fetch_ext_i,
  input logic             boot_irq_i
);
  AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_done_i |-> !core_run_i && !bm_rd_i && !pm_we_i && !boot_irq_i); // R1
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_done_i && $past(hold_done_i) |-> $stable(mode_sel_i)); // R2
  AST_BUS_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_done_i && bus_req_i && !host_arm_i && !core_run_i && !bm_rd_i && !pm_we_i)
      |=> !core_run_i && !bm_rd_i); // R4
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_rd_i && $past(bm_rd_i) |-> bm_addr_i == $past(bm_addr_i) + 1'b1); // R5
  AST_WRITE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_we_i |-> !core_run_i); // R6
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_irq_i |=> !boot_irq_i); // R7
  AST_IRQ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_irq_i |-> $past(pm_we_i) && core_run_i); // R7
  AST_EXT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ext_i |-> !bm_rd_i && !pm_we_i && !boot_irq_i && core_run_i); // R8
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_run_i |=> core_run_i); // R10
endmodule

bind boot_seq_ctrl boot_seq_chk #(.BM_AW(BM_AW)) u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .hold_done_i(hold_done),
  .mode_sel_i(mode_sel),
  .host_arm_i(state_q == ST_HOST),
  .bus_req_i(bus_req_i),
  .bm_rd_i(bm_rd_o),
  .bm_addr_i(bm_addr_o),
  .pm_we_i(pm_we_o),
  .core_run_i(core_run_o),
  .fetch_ext_i(fetch_ext_o),
  .boot_irq_i(boot_irq_o)
);

// File: tb/tb_boot_seq_ctrl.sv
`timescale 1ns/1ps
module tb_boot_seq_ctrl;
  localparam int H  = 16;
  localparam int W  = 32;
  localparam int NB = 3 * W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_pins = 3'b000;
  logic        bus_req = 1'b0;
  logic        bm_rd;
  logic [21:0] bm_addr;
  logic [7:0]  bm_data = 8'h00;
  logic        pm_we;
  logic [13:0] pm_addr;
  logic [23:0] pm_wdata;
  logic        host_we = 1'b0;
  logic [13:0] host_addr = '0;
  logic        core_run, fetch_ext, boot_done, boot_irq;

  int checks = 0, fails = 0, irq_seen = 0, rd_seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  boot_seq_ctrl #(.HOLD_CYCLES(H), .BOOT_WORDS(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_pins), .bus_req_i(bus_req),
    .bm_rd_o(bm_rd), .bm_addr_o(bm_addr), .bm_data_i(bm_data),
    .pm_we_o(pm_we), .pm_addr_o(pm_addr), .pm_wdata_o(pm_wdata),
    .host_we_i(host_we), .host_addr_i(host_addr),
    .core_run_o(core_run), .fetch_ext_o(fetch_ext),
    .boot_done_o(boot_done), .boot_irq_o(boot_irq)
  );

  function automatic logic [7:0] rom(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // byte memory: one-cycle read latency
  always @(posedge clk) bm_data <= bm_rd ? rom(int'(bm_addr)) : 8'h00;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 wait, 1 load, 2 host, 3 run
  int m_cnt, m_ph, m_k;
  logic [2:0] m_mode;
  bit m_irq, m_ext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_k = 0; m_mode = '0; m_irq = 0; m_ext = 0;
    end else begin
      m_irq = 0;
      if (m_cnt < H) begin
        m_mode = mode_pins;
        m_cnt++;
      end else begin
        case (m_ph)
          0: if (!bus_req) begin
               if (m_mode[1] && !m_mode[2]) begin m_ph = 3; m_ext = 1; end
               else if (m_mode[2] && m_mode[0]) m_ph = 2;
               else begin m_ph = 1; m_k = 0; end
             end
          1: if (m_k == NB) begin m_ph = 3; m_irq = 1; end
             else m_k++;
          2: if (host_we && host_addr == 0) m_ph = 3;
          default: ;
        endcase
      end
    end
  end

  always begin
    @(posedge clk); #5;
    begin
      bit e_run, e_rd, e_we;
      string tag;
      e_run = (m_ph == 3);
      e_rd  = (m_ph == 1) && (m_k < NB);
      e_we  = (m_ph == 1) && (m_k >= 3) && (m_k % 3 == 0);
      if (!rst_n) tag = "R11";
      else if (m_cnt < H) tag = "R1";
      else if (m_ph == 0) tag = "R4";
      else if (m_ph == 1) tag = "R5";
      else if (m_ph == 2) tag = "R9";
      else tag = "R10";
      chk(core_run == e_run, {tag, " run"}, core_run, e_run);
      chk(boot_done == e_run, {tag, " done"}, boot_done, e_run);
      chk(bm_rd == e_rd, {tag, " rd"}, bm_rd, e_rd);
      chk(pm_we == e_we, "R6 we", pm_we, e_we);
      chk(boot_irq == m_irq, "R7 irq", boot_irq, m_irq);
      chk(fetch_ext == m_ext, "R8 ext", fetch_ext, m_ext);
      if (e_rd) chk(bm_addr == 22'(m_k), "R5 addr", bm_addr, m_k);
      if (e_we) begin
        int w;
        logic [23:0] ew;
        w  = m_k / 3 - 1;
        ew = {rom(3*w), rom(3*w+1), rom(3*w+2)};
        chk(pm_addr == 14'(w), "R6 addr", pm_addr, w);
        chk(pm_wdata == ew, "R6 data", pm_wdata, ew);
      end
      if (boot_irq) irq_seen++;
      if (bm_rd) rd_seen++;
    end
  end

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode_pins = m; host_we = 0; bus_req = 0;
    irq_seen = 0; rd_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // reset state
    #5;
    chk(!core_run && !bm_rd && !pm_we && !boot_irq && !fetch_ext, "R1 reset", core_run, 0);

    // byte-load, plain strap, with a stray host write to 0 mid-load
    do_reset(3'b000);
    repeat (H + 30) @(negedge clk);
    host_we = 1; host_addr = 0;
    @(negedge clk); host_we = 0;
    repeat (100) @(negedge clk);
    chk(irq_seen == 1, "R7 irq count", irq_seen, 1);
    chk(core_run && !fetch_ext, "R7 run internal", core_run, 1);

    // no-load; pins change after latch
    do_reset(3'b010);
    repeat (H + 3) @(negedge clk);
    mode_pins = 3'b000;
    repeat (20) @(negedge clk);
    chk(fetch_ext && rd_seen == 0, "R2 latched no-load", rd_seen, 0);
    chk(irq_seen == 0, "R8 no irq", irq_seen, 0);

    // host-load: write to 0 on the start edge is ignored, then addr 5, then 0
    do_reset(3'b101);
    repeat (H) @(negedge clk);
    host_we = 1; host_addr = 0;
    @(negedge clk); host_we = 0;
    repeat (4) @(negedge clk);
    chk(!core_run, "R9 early write ignored", core_run, 0);
    host_we = 1; host_addr = 14'd5;
    @(negedge clk); host_we = 0;
    repeat (3) @(negedge clk);
    chk(!core_run, "R9 nonzero addr ignored", core_run, 0);
    host_we = 1; host_addr = 0;
    @(negedge clk); host_we = 0;
    @(negedge clk);
    chk(core_run && irq_seen == 0 && !fetch_ext, "R9 release", core_run, 1);

    // byte-load via c=1,a=0 with bus request held after the hold
    do_reset(3'b100);
    bus_req = 1;
    repeat (H + 10) @(negedge clk);
    chk(!core_run && rd_seen == 0, "R4 bus blocks", rd_seen, 0);
    bus_req = 0;
    repeat (110) @(negedge clk);
    chk(rd_seen == NB, "R3 c=1 a=0 byte load", rd_seen, NB);
    chk(irq_seen == 1 && core_run, "R7 done", irq_seen, 1);

    // pins change during hold: last hold sample wins
    do_reset(3'b101);
    repeat (H - 2) @(negedge clk);
    mode_pins = 3'b011;
    repeat (10) @(negedge clk);
    chk(fetch_ext && core_run, "R2 last sample", fetch_ext, 1);
    chk(fetch_ext, "R3 b=1 c=0 no-load", fetch_ext, 1);

    // reset in the middle of a load
    do_reset(3'b000);
    repeat (H + 30) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!bm_rd && !pm_we && !core_run && !boot_done && !boot_irq && !fetch_ext,
        "R11 mid-load reset", bm_rd, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (H + 110) @(negedge clk);
    chk(core_run && irq_seen == 1, "R11 reload after reset", irq_seen, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule